// File: doc/BRIEF.md
# Dual-Bank Receive Endpoint Buffer

This block holds the received payload of one host-to-device endpoint in one or two 64-byte banks. A bus-side writer marks the start of a packet, presents bytes with a valid strobe and closes the packet with an end strobe. The block then answers with a one-cycle acknowledge pulse if a free bank took the packet, or with a one-cycle refusal pulse if no bank was free. Banks are filled in turn and are handed to the processor in the same order.

The processor sees only the current bank. It sees a received flag, an ownership flag that stays set while the current bank holds a packet, a read-ready flag, the byte count latched at the end of the packet and a byte read port with a read strobe. An interrupt output follows the received flag, gated by an enable. The processor first acknowledges the received flag. It then drains the bank and hands the bank back by clearing the ownership flag. In the automatic mode, hardware hands the bank back as soon as the last byte has been read. In either mode, the flags are then reloaded from the next bank.

Top module: `rxep_bank_ctrl`

## Requirements
- R1: After reset, the received flag, ownership flag, read-ready flag, interrupt, byte count, acknowledge and refusal outputs are all 0.
- R2: When a packet's end strobe is sampled, exactly one of `hs_ack` (bank accepted it) or `hs_nak` (no free bank) is high during the following cycle only. With two banks the third unreleased packet is refused.
- R3: `byte_cnt` shows the number of bytes of the packet in the current bank, latched at the end strobe. A packet longer than 64 bytes keeps its first 64 bytes and reports 64.
- R4: When the current bank receives a packet, `done_flag` and `release_flag` become 1. `irq` is 1 exactly while `done_flag` and `cfg_irq_en` are both 1.
- R5: `rd_data` presents the current bank's bytes in arrival order, and each `rd_en` with `read_ok` high advances by one byte. `read_ok` is 1 while unread bytes remain and drops to 0 once the bank is read out. Strobes while it is 0 do nothing.
- R6: A pulse on `sw_clr_release` while `done_flag` is 1 is ignored: the bank, flags and count stay as they were.
- R7: With `cfg_auto`=0, reading never releases a bank. A pulse on `sw_clr_release` with `done_flag` at 0 frees the current bank. With `cfg_dual`=1 the other bank then becomes current, and `done_flag`/`release_flag` are reloaded to 1 if that bank holds a packet, or to 0 if it does not.
- R8: With `cfg_auto`=1, reading the last byte of the current bank frees it with no processor write, and the flags and count then track the next bank in the same way as in R7.
- R9: Only a pulse on `sw_clr_done` clears `done_flag`. Reading bytes and automatic bank switches never clear it.
- R10: With `cfg_dual`=0 only one bank is used. A second packet is refused until the processor releases the bank, and the next packet then lands in the same bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dual | input | 1 | 1: two banks, 0: one bank |
| cfg_auto | input | 1 | 1: hardware releases a bank once it is read out |
| cfg_irq_en | input | 1 | Receive interrupt enable |
| pkt_start | input | 1 | Start of an incoming packet |
| pkt_valid | input | 1 | `pkt_data` holds a payload byte |
| pkt_data | input | 8 | Payload byte |
| pkt_end | input | 1 | End of the packet |
| hs_ack | output | 1 | Packet accepted (one-cycle pulse) |
| hs_nak | output | 1 | Packet refused (one-cycle pulse) |
| sw_clr_done | input | 1 | Processor clears the received flag |
| sw_clr_release | input | 1 | Processor clears the ownership flag |
| rd_en | input | 1 | Consume the byte on `rd_data` |
| rd_data | output | 8 | Next unread byte of the current bank |
| done_flag | output | 1 | Received flag |
| release_flag | output | 1 | Ownership flag: current bank holds a packet |
| read_ok | output | 1 | Unread bytes remain in the current bank |
| byte_cnt | output | 7 | Byte count of the current bank |
| irq | output | 1 | Endpoint interrupt |

## Verification
A bank pointer out of step between the fill and drain sides shows up as a payload byte mismatch on the first read after the switch. It also shows as a wrong `byte_cnt` in the cycle right after the release. A full-bit that stays set or clears wrongly shows up as a refusal or acceptance pulse of the wrong kind, one cycle after the next end strobe. Errors in the flag reload show up as wrong values of `done_flag`, `release_flag` or `irq` one cycle after the release pulse or the last read. The payload scoreboard checks every byte in order across bank switches, so a lost, repeated or skipped byte is caught at the read where it happens.

// File: rtl/rxep_pkg.sv
package rxep_pkg;
  localparam int NUM_BANKS = 2;

  // Bank that follows `cur`; single-bank mode always stays on bank 0.
  function automatic logic next_bank(input logic cur, input logic dual);
    return dual ? ~cur : 1'b0;
  endfunction

  // A bank may take a new packet only while it holds none.
  function automatic logic bank_free(input logic [NUM_BANKS-1:0] full, input logic idx);
    return !full[idx];
  endfunction
endpackage

// File: rtl/rxep_bank_mem.sv
module rxep_bank_mem #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_bank,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data
);
  logic [DW-1:0] rd_word [rxep_pkg::NUM_BANKS];

  for (genvar b = 0; b < rxep_pkg::NUM_BANKS; b++) begin : g_bank
    logic [DW-1:0] store [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 1'(b))) store[wr_addr] <= wr_data;
    end
    assign rd_word[b] = store[rd_addr];
  end

  assign rd_data = rd_word[rd_bank];
endmodule

// File: rtl/rxep_fill.sv
module rxep_fill #(
  parameter int DEPTH = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dual,
  input  logic              pkt_start,
  input  logic              pkt_valid,
  input  logic              pkt_end,
  input  logic [1:0]        bank_full,
  output logic              wr_en,
  output logic              wr_bank,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              fill_evt,
  output logic              fill_bank,
  output logic [CNT_W-1:0]  fill_cnt,
  output logic              hs_ack,
  output logic              hs_nak
);
  import rxep_pkg::*;

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic             wbank_q, in_pkt_q, taking_q, ack_q, nak_q;
  logic [CNT_W-1:0] widx_q;
  logic [CNT_W-1:0] widx_nx;

  assign wr_en     = taking_q && pkt_valid && !pkt_start && (widx_q < DEPTH_C);
  assign wr_bank   = wbank_q;
  assign wr_addr   = widx_q[ADDR_W-1:0];
  assign widx_nx   = wr_en ? widx_q + CNT_W'(1) : widx_q;
  assign fill_evt  = taking_q && pkt_end && !pkt_start;
  assign fill_bank = wbank_q;
  assign fill_cnt  = widx_nx;
  assign hs_ack    = ack_q;
  assign hs_nak    = nak_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wbank_q  <= 1'b0;
      in_pkt_q <= 1'b0;
      taking_q <= 1'b0;
      ack_q    <= 1'b0;
      nak_q    <= 1'b0;
      widx_q   <= '0;
    end else begin
      ack_q <= 1'b0;
      nak_q <= 1'b0;
      if (pkt_start) begin
        in_pkt_q <= 1'b1;
        taking_q <= bank_free(bank_full, wbank_q);
        widx_q   <= '0;
      end else begin
        widx_q <= widx_nx;
        if (pkt_end && in_pkt_q) begin
          in_pkt_q <= 1'b0;
          taking_q <= 1'b0;
          ack_q    <= taking_q;
          nak_q    <= !taking_q;
          if (taking_q) wbank_q <= next_bank(wbank_q, cfg_dual);
        end
      end
    end
  end
endmodule

// File: rtl/rxep_drain.sv
module rxep_drain #(
  parameter int DEPTH = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dual,
  input  logic              cfg_auto,
  input  logic              sw_clr_done,
  input  logic              sw_clr_release,
  input  logic              rd_en,
  input  logic              fill_evt,
  input  logic              fill_bank,
  input  logic [CNT_W-1:0]  fill_cnt,
  output logic              cur_bank,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        bank_full,
  output logic              done_flag,
  output logic              release_flag,
  output logic              read_ok,
  output logic [CNT_W-1:0]  byte_cnt,
  output logic              rd_evt,
  output logic              sw_rel_evt,
  output logic              auto_rel_evt
);
  import rxep_pkg::*;

  logic [1:0]       full_q, full_n;
  logic [CNT_W-1:0] cnt_q [NUM_BANKS];
  logic [CNT_W-1:0] rptr_q, cur_cnt;
  logic             cur_q, done_q, rel_q;
  logic             last_rd, switch_evt, nxt, done_eff;

  assign cur_cnt    = cnt_q[cur_q];
  assign read_ok    = full_q[cur_q] && (rptr_q < cur_cnt);
  assign rd_evt     = rd_en && read_ok;
  assign last_rd    = rd_evt && ((rptr_q + CNT_W'(1)) == cur_cnt);
  assign auto_rel_evt = cfg_auto && last_rd;
  assign sw_rel_evt = sw_clr_release && rel_q && !done_q && !auto_rel_evt;
  assign switch_evt = sw_rel_evt || auto_rel_evt;
  assign nxt        = next_bank(cur_q, cfg_dual);
  assign done_eff   = done_q && !sw_clr_done;

  always_comb begin
    full_n = full_q;
    if (fill_evt)   full_n[fill_bank] = 1'b1;
    if (switch_evt) full_n[cur_q]     = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= '0;
      cur_q  <= 1'b0;
      rptr_q <= '0;
      done_q <= 1'b0;
      rel_q  <= 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) cnt_q[b] <= '0;
    end else begin
      full_q <= full_n;
      if (fill_evt) cnt_q[fill_bank] <= fill_cnt;
      if (switch_evt) begin
        cur_q  <= nxt;
        rptr_q <= '0;
        rel_q  <= full_n[nxt];
        done_q <= done_eff || full_n[nxt];
      end else begin
        if (rd_evt) rptr_q <= rptr_q + CNT_W'(1);
        if (fill_evt && (fill_bank == cur_q)) begin
          rel_q  <= 1'b1;
          done_q <= 1'b1;
        end else begin
          done_q <= done_eff;
        end
      end
    end
  end

  assign cur_bank     = cur_q;
  assign rd_addr      = rptr_q[ADDR_W-1:0];
  assign bank_full    = full_q;
  assign done_flag    = done_q;
  assign release_flag = rel_q;
  assign byte_cnt     = full_q[cur_q] ? cur_cnt : '0;
endmodule

// File: rtl/rxep_bank_ctrl.sv
module rxep_bank_ctrl #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_dual,
  input  logic             cfg_auto,
  input  logic             cfg_irq_en,
  input  logic             pkt_start,
  input  logic             pkt_valid,
  input  logic [DW-1:0]    pkt_data,
  input  logic             pkt_end,
  output logic             hs_ack,
  output logic             hs_nak,
  input  logic             sw_clr_done,
  input  logic             sw_clr_release,
  input  logic             rd_en,
  output logic [DW-1:0]    rd_data,
  output logic             done_flag,
  output logic             release_flag,
  output logic             read_ok,
  output logic [CNT_W-1:0] byte_cnt,
  output logic             irq
);
  logic              wr_en, wr_bank, fill_evt, fill_bank, cur_bank;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [CNT_W-1:0]  fill_cnt;
  logic [1:0]        bank_full;
  logic              rd_evt, sw_rel_evt, auto_rel_evt;

  rxep_fill #(.DEPTH(DEPTH)) u_fill (
    .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual),
    .pkt_start(pkt_start), .pkt_valid(pkt_valid), .pkt_end(pkt_end),
    .bank_full(bank_full),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .fill_evt(fill_evt), .fill_bank(fill_bank), .fill_cnt(fill_cnt),
    .hs_ack(hs_ack), .hs_nak(hs_nak)
  );

  rxep_bank_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_data(pkt_data), .rd_bank(cur_bank), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  rxep_drain #(.DEPTH(DEPTH)) u_drain (
    .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .cfg_auto(cfg_auto),
    .sw_clr_done(sw_clr_done), .sw_clr_release(sw_clr_release), .rd_en(rd_en),
    .fill_evt(fill_evt), .fill_bank(fill_bank), .fill_cnt(fill_cnt),
    .cur_bank(cur_bank), .rd_addr(rd_addr), .bank_full(bank_full),
    .done_flag(done_flag), .release_flag(release_flag), .read_ok(read_ok),
    .byte_cnt(byte_cnt), .rd_evt(rd_evt), .sw_rel_evt(sw_rel_evt),
    .auto_rel_evt(auto_rel_evt)
  );

  assign irq = done_flag && cfg_irq_en;
endmodule

// File: rtl/rxep_bank_ctrl_chk.sv
module rxep_bank_ctrl_chk #(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_auto,
  input logic             pkt_end,
  input logic             hs_ack,
  input logic             hs_nak,
  input logic             sw_clr_done,
  input logic             sw_clr_release,
  input logic             done_flag,
  input logic             release_flag,
  input logic             read_ok,
  input logic [CNT_W-1:0] byte_cnt,
  input logic             rd_evt,
  input logic             sw_rel_evt,
  input logic             auto_rel_evt
);
  AST_ONE_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_ack && hs_nak)); // R2
  AST_HS_FOLLOWS_END: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_ack || hs_nak) |-> $past(pkt_end)); // R2
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt <= CNT_W'(DEPTH)); // R3
  AST_READ_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    read_ok |-> release_flag); // R5
  AST_EARLY_RELEASE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (release_flag && done_flag && sw_clr_release && !auto_rel_evt) |=> release_flag); // R6
  AST_MANUAL_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_auto && rd_evt && !sw_rel_evt) |=> release_flag); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !sw_clr_done) |=> done_flag); // R9
endmodule

bind rxep_bank_ctrl rxep_bank_ctrl_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/rxep_bank_ctrl_test.sv
module rxep_bank_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_dual = 1'b1, cfg_auto = 1'b0, cfg_irq_en = 1'b1;
  logic pkt_start = 0, pkt_valid = 0, pkt_end = 0;
  logic [7:0] pkt_data = '0;
  logic sw_clr_done = 0, sw_clr_release = 0, rd_en = 0;
  logic hs_ack, hs_nak, done_flag, release_flag, read_ok, irq;
  logic [7:0] rd_data;
  logic [6:0] byte_cnt;

  int n_chk = 0, n_fail = 0;
  bit ended = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  rxep_bank_ctrl uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  // Scoreboard monitor: every accepted read is compared with the oldest expected byte.
  always @(negedge clk) begin
    if (rst_n && rd_en && read_ok) begin
      if (exp_q.size() == 0) chk("R5 unexpected byte", rd_data, -1);
      else chk("R5 payload order", rd_data, exp_q.pop_front());
    end
  end

  task automatic do_reset();
    rst_n = 0; repeat (3) tick(); rst_n = 1; tick();
    @(negedge clk);
    chk("R1 done", done_flag, 0); chk("R1 release", release_flag, 0);
    chk("R1 read_ok", read_ok, 0); chk("R1 irq", irq, 0);
    chk("R1 count", byte_cnt, 0); chk("R1 ack/nak", {hs_ack, hs_nak}, 0);
  endtask

  // Driver: sends a packet and pushes the bytes the design should keep.
  task automatic send_pkt(input int n, input logic [7:0] base, input bit accept);
    tick(); pkt_start = 1; tick(); pkt_start = 0;
    for (int i = 0; i < n; i++) begin
      pkt_valid = 1; pkt_data = base + 8'(i);
      if (accept && i < 64) exp_q.push_back(base + 8'(i));
      tick();
    end
    pkt_valid = 0; pkt_end = 1; tick(); pkt_end = 0;
    @(negedge clk);
    chk(accept ? "R2 ack" : "R2 nak", {hs_ack, hs_nak}, accept ? 2 : 1);
    tick(); @(negedge clk);
    chk("R2 one-cycle pulse", {hs_ack, hs_nak}, 0);
  endtask

  task automatic read_bytes(input int n);
    for (int i = 0; i < n; i++) begin tick(); rd_en = 1; end
    tick(); rd_en = 0; @(negedge clk);
  endtask

  task automatic pulse_done(); tick(); sw_clr_done = 1; tick(); sw_clr_done = 0; @(negedge clk); endtask
  task automatic pulse_rel();  tick(); sw_clr_release = 1; tick(); sw_clr_release = 0; @(negedge clk); endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // Two banks, firmware releases
    send_pkt(5, 8'h10, 1);
    chk("R4 done", done_flag, 1); chk("R4 release", release_flag, 1);
    chk("R4 irq", irq, 1); chk("R3 count", byte_cnt, 5); chk("R5 read_ok", read_ok, 1);
    send_pkt(3, 8'h40, 1);
    chk("R3 count of current bank", byte_cnt, 5);
    send_pkt(2, 8'h70, 0);
    read_bytes(5);
    chk("R5 read_ok after drain", read_ok, 0);
    chk("R7 release kept after reads", release_flag, 1);
    chk("R9 done kept after reads", done_flag, 1);
    tick(); rd_en = 1; tick(); rd_en = 0; @(negedge clk);
    chk("R5 read ignored when empty", read_ok, 0);
    pulse_rel();
    chk("R6 release held", release_flag, 1); chk("R6 count held", byte_cnt, 5);
    pulse_done();
    chk("R9 done cleared by write", done_flag, 0); chk("R4 irq follows", irq, 0);
    pulse_rel();
    chk("R7 switch count", byte_cnt, 3); chk("R7 reload release", release_flag, 1);
    chk("R7 reload done", done_flag, 1); chk("R7 read_ok", read_ok, 1);
    read_bytes(3);
    pulse_done(); pulse_rel();
    chk("R7 empty bank release", release_flag, 0); chk("R7 empty bank done", done_flag, 0);
    chk("R7 empty bank count", byte_cnt, 0);
    // Oversized packet
    send_pkt(70, 8'h00, 1);
    chk("R3 saturated count", byte_cnt, 64);
    read_bytes(64);
    pulse_done(); pulse_rel();
    // Automatic release
    cfg_auto = 1;
    send_pkt(4, 8'h80, 1);
    send_pkt(2, 8'h90, 1);
    read_bytes(4);
    chk("R8 auto switch count", byte_cnt, 2); chk("R8 auto release", release_flag, 1);
    chk("R9 done survives auto switch", done_flag, 1); chk("R8 read_ok", read_ok, 1);
    pulse_done();
    read_bytes(2);
    chk("R8 auto to empty release", release_flag, 0); chk("R8 auto to empty count", byte_cnt, 0);
    chk("R8 done stays clear", done_flag, 0);
    // Single bank
    cfg_auto = 0; cfg_dual = 0;
    do_reset();
    send_pkt(6, 8'hA0, 1);
    send_pkt(2, 8'hB0, 0);
    chk("R10 count after refusal", byte_cnt, 6);
    read_bytes(6);
    pulse_done(); pulse_rel();
    chk("R10 release", release_flag, 0);
    send_pkt(2, 8'hC0, 1);
    chk("R10 reuse count", byte_cnt, 2); chk("R10 done", done_flag, 1);
    read_bytes(2);
    chk("R5 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule